// File: doc/BRIEF.md
# Vectored priority interrupt controller

This block gathers 32 level-sensitive, active-high interrupt request lines. Each line may also be raised from software through a soft-request register. Each enabled line is steered to one of two processor request outputs, both active low: a fast request or a general request. For the general request, the block chooses a winner by priority. There are sixteen programmable vector slots; slot 0 is the highest, and each slot names one source line. A default class sits below all slots and holds every general request that no enabled slot claims. The block hands out the service-routine address of the winner.

Software reads the vector register to take the interrupt. That read returns the winner's address, and it also marks the winner's level as in service. The in-service mark blocks that level and every lower one, while a higher level can still preempt and nest. Any write to the vector register ends the most urgent service in progress. Both request outputs are formed combinationally from the lines and the stored configuration, so they respond while the bus clock is stopped.

In-service tracking is a small state machine with two named states. `ISR_IDLE` means no level is in service. `ISR_NESTED` means at least one level is in service. The transition *take* (`ISR_IDLE`→`ISR_NESTED`) happens on a vector read that has a live winner. Further takes and ends keep the machine in `ISR_NESTED` while any mark remains. The transition *unwind* (`ISR_NESTED`→`ISR_IDLE`) happens on the end write that clears the last mark.

Top module: `vec_intc`

Register word addresses:

| Address | Name | Access |
|---|---|---|
| 0x00 | raw status | read |
| 0x01 | fast status | read |
| 0x02 | general status | read |
| 0x03 | enable | read, write-1-to-set |
| 0x04 | enable clear | write-1-to-clear |
| 0x05 | fast select | read and write; 1 = fast |
| 0x06 | soft request | read and write |
| 0x08 | vector | read = take, write = end |
| 0x09 | default address | read and write |
| 0x20+n | slot n control | bit 5 = enable, bits 4:0 = source line |
| 0x30+n | slot n address | read and write |

## Requirements
- R1: The raw status at word 0x00 equals the hardware lines OR the soft-request register at word 0x06. That register reads back what was written, and a soft bit by itself raises a request.
- R2: Writing ones to word 0x03 sets enable bits, and writing ones to word 0x04 clears them. A line whose enable bit is clear appears in neither masked status and drives neither output. The general status at word 0x02 is raw AND enable AND NOT select.
- R3: nfiq_o is low exactly when some line is raw, enabled and fast-selected (select bit 1). It follows the inputs with no clock edge.
- R4: nirq_o is low exactly when an unmasked general request is pending. nirq_o and nfiq_o can both be low at once.
- R5: Among the enabled slots whose source line is pending as a general request, the lowest-numbered slot wins. A pending general line that no enabled slot names is served by the default class, which ranks below every slot, and a read of word 0x08 then returns the default address at word 0x09.
- R6: A read of word 0x08 while a winner exists marks the winner's level in service. Requests at that level and lower are then masked from nirq_o, while a higher level still drives nirq_o low and can nest.
- R7: Any write to word 0x08 clears the highest-priority in-service mark, which is the lowest level number. This unwinds nested service one level per write.
- R8: A read of word 0x08 with no live winner returns the address last latched for a winner and marks no level. Lower-priority requests then still assert nirq_o.
- R9: A fast-selected line never takes part in vector selection, even when an enabled slot names it.
- R10: After reset, both outputs are high, all registers read as zero, and a read of word 0x08 returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_i | input | 32 | Level request lines, active high |
| bus_addr_i | input | 6 | Register word address |
| bus_wr_i | input | 1 | Write strobe for one cycle |
| bus_rd_i | input | 1 | Read strobe for one cycle; the read takes effect at the edge |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational from the address |
| nfiq_o | output | 1 | Fast request, active low |
| nirq_o | output | 1 | General request, active low |

## Verification
Requests are applied as single lines, as pairs of slot lines, and as a slot line mixed with a line no slot names. These patterns separate lowest-slot-wins from default-class fallback. Fast-only and fast-plus-general patterns show that the two outputs are independent and that a fast line stays out of vector selection. A nested sequence of slots 3, 1 and 0, with a lower line added while they are in service, separates masking of same and lower levels from preemption by higher ones, and the end writes show the unwind order. A request that drops before its read separates the latched address from a live one, and confirms that no level gets marked.

// File: rtl/vec_intc_pkg.sv
package vec_intc_pkg;
    localparam int ADDR_W = 6;

    localparam logic [ADDR_W-1:0] REG_RAW   = 6'h00;
    localparam logic [ADDR_W-1:0] REG_FAST  = 6'h01;
    localparam logic [ADDR_W-1:0] REG_GEN   = 6'h02;
    localparam logic [ADDR_W-1:0] REG_ENSET = 6'h03;
    localparam logic [ADDR_W-1:0] REG_ENCLR = 6'h04;
    localparam logic [ADDR_W-1:0] REG_SEL   = 6'h05;
    localparam logic [ADDR_W-1:0] REG_SOFT  = 6'h06;
    localparam logic [ADDR_W-1:0] REG_VEC   = 6'h08;
    localparam logic [ADDR_W-1:0] REG_DEF   = 6'h09;
    localparam logic [ADDR_W-1:0] SLOT_CTL_BASE = 6'h20;
    localparam logic [ADDR_W-1:0] SLOT_ADR_BASE = 6'h30;

    typedef enum logic [0:0] {
        ISR_IDLE   = 1'b0,
        ISR_NESTED = 1'b1
    } isr_state_e;
endpackage

// File: rtl/vec_intc_resolve.sv
module vec_intc_resolve #(
    parameter int N_LINES = 32,
    parameter int N_SLOTS = 16,
    parameter int SRC_W   = $clog2(N_LINES),
    parameter int LVL_W   = $clog2(N_SLOTS) + 1
) (
    input  logic [N_LINES-1:0]            gen_stat,
    input  logic [N_SLOTS-1:0]            slot_en,
    input  logic [N_SLOTS-1:0][SRC_W-1:0] slot_src,
    input  logic [N_SLOTS:0]              isr_mask,
    output logic                          win_valid,
    output logic [LVL_W-1:0]              win_lvl
);
    logic [N_SLOTS-1:0] slot_hit;
    logic [N_LINES-1:0] claimed;
    logic               dflt_hit;
    logic [N_SLOTS:0]   lvl_req;

    for (genvar s = 0; s < N_SLOTS; s++) begin : g_hit
        assign slot_hit[s] = slot_en[s] & gen_stat[slot_src[s]];
    end

    always_comb begin
        claimed = '0;
        for (int s = 0; s < N_SLOTS; s++) begin
            if (slot_en[s]) claimed[slot_src[s]] = 1'b1;
        end
    end

    assign dflt_hit = |(gen_stat & ~claimed);
    assign lvl_req  = {dflt_hit, slot_hit};

    always_comb begin
        logic blocked;
        blocked   = 1'b0;
        win_valid = 1'b0;
        win_lvl   = '0;
        for (int l = 0; l <= N_SLOTS; l++) begin
            blocked = blocked | isr_mask[l];
            if (!win_valid && !blocked && lvl_req[l]) begin
                win_valid = 1'b1;
                win_lvl   = LVL_W'(l);
            end
        end
    end
endmodule

// File: rtl/vec_intc_isr.sv
module vec_intc_isr
    import vec_intc_pkg::*;
#(
    parameter int N_LVL = 17,
    parameter int LVL_W = $clog2(N_LVL)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take,
    input  logic [LVL_W-1:0] take_lvl,
    input  logic             finish,
    output logic [N_LVL-1:0] isr_mask,
    output isr_state_e       state
);
    isr_state_e       state_d;
    logic [N_LVL-1:0] mask_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ISR_IDLE;
            isr_mask <= '0;
        end else begin
            state    <= state_d;
            isr_mask <= mask_d;
        end
    end

    always_comb begin
        mask_d  = isr_mask;
        state_d = state;
        unique case (state)
            ISR_IDLE: begin
                if (take) begin
                    mask_d  = N_LVL'(1) << take_lvl;
                    state_d = ISR_NESTED;
                end
            end
            ISR_NESTED: begin
                if (take) begin
                    mask_d = isr_mask | (N_LVL'(1) << take_lvl);
                end else if (finish) begin
                    mask_d = isr_mask & (isr_mask - N_LVL'(1));
                    if (mask_d == '0) state_d = ISR_IDLE;
                end
            end
            default: state_d = ISR_IDLE;
        endcase
    end
endmodule

// File: rtl/vec_intc.sv
module vec_intc
    import vec_intc_pkg::*;
#(
    parameter int N_LINES = 32,
    parameter int N_SLOTS = 16,
    parameter int DATA_W  = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] irq_i,
    input  logic [ADDR_W-1:0]  bus_addr_i,
    input  logic               bus_wr_i,
    input  logic               bus_rd_i,
    input  logic [DATA_W-1:0]  bus_wdata_i,
    output logic [DATA_W-1:0]  bus_rdata_o,
    output logic               nfiq_o,
    output logic               nirq_o
);
    localparam int SRC_W  = $clog2(N_LINES);
    localparam int SLOT_W = $clog2(N_SLOTS);
    localparam int LVL_W  = SLOT_W + 1;
    localparam int N_LVL  = N_SLOTS + 1;

    logic [N_LINES-1:0]            en_q, sel_q, soft_q;
    logic [N_LINES-1:0]            raw_stat, fast_stat, gen_stat;
    logic [DATA_W-1:0]             def_q, last_q, win_addr, vec_view;
    logic [N_SLOTS-1:0]            slot_en_q;
    logic [N_SLOTS-1:0][SRC_W-1:0] slot_src_q;
    logic [N_SLOTS-1:0][DATA_W-1:0] slot_adr_q;
    logic                          win_valid, take, finish;
    logic [LVL_W-1:0]              win_lvl;
    logic [N_LVL-1:0]              isr_mask;
    isr_state_e                    isr_state;

    assign raw_stat  = irq_i | soft_q;
    assign fast_stat = raw_stat & en_q & sel_q;
    assign gen_stat  = raw_stat & en_q & ~sel_q;

    vec_intc_resolve #(
        .N_LINES(N_LINES), .N_SLOTS(N_SLOTS), .SRC_W(SRC_W), .LVL_W(LVL_W)
    ) u_resolve (
        .gen_stat (gen_stat),
        .slot_en  (slot_en_q),
        .slot_src (slot_src_q),
        .isr_mask (isr_mask),
        .win_valid(win_valid),
        .win_lvl  (win_lvl)
    );

    assign take   = bus_rd_i && (bus_addr_i == REG_VEC) && win_valid;
    assign finish = bus_wr_i && (bus_addr_i == REG_VEC);

    vec_intc_isr #(.N_LVL(N_LVL), .LVL_W(LVL_W)) u_isr (
        .clk     (clk),
        .rst_n   (rst_n),
        .take    (take),
        .take_lvl(win_lvl),
        .finish  (finish),
        .isr_mask(isr_mask),
        .state   (isr_state)
    );

    assign win_addr = win_lvl[SLOT_W] ? def_q : slot_adr_q[win_lvl[SLOT_W-1:0]];
    assign vec_view = win_valid ? win_addr : last_q;

    assign nfiq_o = ~|fast_stat;
    assign nirq_o = ~win_valid;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q       <= '0;
            sel_q      <= '0;
            soft_q     <= '0;
            def_q      <= '0;
            last_q     <= '0;
            slot_en_q  <= '0;
            slot_src_q <= '0;
            slot_adr_q <= '0;
        end else begin
            if (win_valid) last_q <= win_addr;
            if (bus_wr_i) begin
                unique case (bus_addr_i)
                    REG_ENSET: en_q   <= en_q | bus_wdata_i[N_LINES-1:0];
                    REG_ENCLR: en_q   <= en_q & ~bus_wdata_i[N_LINES-1:0];
                    REG_SEL:   sel_q  <= bus_wdata_i[N_LINES-1:0];
                    REG_SOFT:  soft_q <= bus_wdata_i[N_LINES-1:0];
                    REG_DEF:   def_q  <= bus_wdata_i;
                    default: ;
                endcase
                for (int s = 0; s < N_SLOTS; s++) begin
                    if (bus_addr_i == SLOT_CTL_BASE + ADDR_W'(s)) begin
                        slot_en_q[s]  <= bus_wdata_i[SRC_W];
                        slot_src_q[s] <= bus_wdata_i[SRC_W-1:0];
                    end
                    if (bus_addr_i == SLOT_ADR_BASE + ADDR_W'(s)) begin
                        slot_adr_q[s] <= bus_wdata_i;
                    end
                end
            end
        end
    end

    always_comb begin
        bus_rdata_o = '0;
        unique case (bus_addr_i)
            REG_RAW:   bus_rdata_o = DATA_W'(raw_stat);
            REG_FAST:  bus_rdata_o = DATA_W'(fast_stat);
            REG_GEN:   bus_rdata_o = DATA_W'(gen_stat);
            REG_ENSET: bus_rdata_o = DATA_W'(en_q);
            REG_SEL:   bus_rdata_o = DATA_W'(sel_q);
            REG_SOFT:  bus_rdata_o = DATA_W'(soft_q);
            REG_VEC:   bus_rdata_o = vec_view;
            REG_DEF:   bus_rdata_o = def_q;
            default: ;
        endcase
        for (int s = 0; s < N_SLOTS; s++) begin
            if (bus_addr_i == SLOT_CTL_BASE + ADDR_W'(s))
                bus_rdata_o = DATA_W'({slot_en_q[s], slot_src_q[s]});
            if (bus_addr_i == SLOT_ADR_BASE + ADDR_W'(s))
                bus_rdata_o = slot_adr_q[s];
        end
    end
endmodule

// File: rtl/vec_intc_checker.sv
module vec_intc_checker
    import vec_intc_pkg::*;
#(
    parameter int N_LINES = 32,
    parameter int N_SLOTS = 16,
    parameter int SRC_W   = 5,
    parameter int LVL_W   = 5
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          bus_rd_i,
    input logic                          bus_wr_i,
    input logic [ADDR_W-1:0]             bus_addr_i,
    input logic                          win_valid,
    input logic [LVL_W-1:0]              win_lvl,
    input logic [N_SLOTS:0]              isr_mask,
    input logic [N_LINES-1:0]            sel_q,
    input logic [N_SLOTS-1:0][SRC_W-1:0] slot_src_q
);
    localparam int N_LVL = N_SLOTS + 1;
    localparam int SLOT_W = LVL_W - 1;

    logic [N_LVL-1:0] upto_win;
    assign upto_win = (N_LVL'(2) << win_lvl) - N_LVL'(1);

    assert_slot_not_fast_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (win_valid && !win_lvl[SLOT_W]) |-> !sel_q[slot_src_q[win_lvl[SLOT_W-1:0]]]);

    assert_winner_unmasked_R6: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid |-> ((isr_mask & upto_win) == '0));

    assert_take_marks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd_i && bus_addr_i == REG_VEC && win_valid) |=> isr_mask[$past(win_lvl)]);

    assert_end_clears_one_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_i && bus_addr_i == REG_VEC && isr_mask != '0)
        |=> ($countones(isr_mask) == $countones($past(isr_mask)) - 1));
endmodule

bind vec_intc vec_intc_checker #(
    .N_LINES(N_LINES), .N_SLOTS(N_SLOTS), .SRC_W(SRC_W), .LVL_W(LVL_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_rd_i  (bus_rd_i),
    .bus_wr_i  (bus_wr_i),
    .bus_addr_i(bus_addr_i),
    .win_valid (win_valid),
    .win_lvl   (win_lvl),
    .isr_mask  (isr_mask),
    .sel_q     (sel_q),
    .slot_src_q(slot_src_q)
);

// File: tb/vec_intc_bench.sv
module vec_intc_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] irq = '0;
    logic [5:0]  addr = '0;
    logic        wr = 1'b0, rd = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        nfiq, nirq;
    int          n_run = 0, n_fail = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    vec_intc u_vec_intc (
        .clk(clk), .rst_n(rst_n), .irq_i(irq), .bus_addr_i(addr),
        .bus_wr_i(wr), .bus_rd_i(rd), .bus_wdata_i(wdata),
        .bus_rdata_o(rdata), .nfiq_o(nfiq), .nirq_o(nirq)
    );

    typedef struct packed {
        logic [31:0] lines;
        logic        exp_nirq;
        logic        exp_nfiq;
        logic [31:0] exp_addr;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t TABLE [NV] = '{
        '{32'h0000_2000, 1'b0, 1'b1, 32'h0000_1030},
        '{32'h0000_2800, 1'b0, 1'b1, 32'h0000_1010},
        '{32'h0010_0020, 1'b0, 1'b1, 32'h0000_10F0},
        '{32'h0000_0020, 1'b0, 1'b1, 32'h0000_DEF0},
        '{32'h0000_0004, 1'b1, 1'b0, 32'h0000_DEF0},
        '{32'h0000_0404, 1'b0, 1'b0, 32'h0000_1000},
        '{32'h0000_0000, 1'b1, 1'b1, 32'h0000_1000}
    };

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got %h expected %h", req, got, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic bus_write(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk); addr = a; wdata = d; wr = 1'b1;
        @(posedge clk); #1; wr = 1'b0;
    endtask

    task automatic bus_read(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk); addr = a; rd = 1'b1; #1; d = rdata;
        @(posedge clk); #1; rd = 1'b0;
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        #20; rst_n = 1'b1; tick();

        // R10 reset state
        check("R10 nirq", {31'b0, nirq}, 32'd1);
        check("R10 nfiq", {31'b0, nfiq}, 32'd1);
        bus_read(6'h03, d); check("R10 enable", d, 32'h0);
        bus_read(6'h08, d); check("R10 vector", d, 32'h0);

        bus_write(6'h03, 32'hFFFF_FFFF);
        bus_write(6'h05, 32'h0000_0004);
        bus_write(6'h09, 32'h0000_DEF0);
        bus_write(6'h20, 32'h2A); bus_write(6'h30, 32'h1000);
        bus_write(6'h21, 32'h2B); bus_write(6'h31, 32'h1010);
        bus_write(6'h23, 32'h2D); bus_write(6'h33, 32'h1030);
        bus_write(6'h2F, 32'h34); bus_write(6'h3F, 32'h10F0);
        // R9: slot 2 names fast line 2
        bus_write(6'h22, 32'h22); bus_write(6'h32, 32'h1020);

        // R4 R5 R8 R9 table walk
        for (int i = 0; i < NV; i++) begin
            irq = TABLE[i].lines;
            tick();
            check($sformatf("R4 nirq vec%0d", i), {31'b0, nirq}, {31'b0, TABLE[i].exp_nirq});
            check($sformatf("R3 nfiq vec%0d", i), {31'b0, nfiq}, {31'b0, TABLE[i].exp_nfiq});
            bus_read(6'h08, d);
            check($sformatf("R5 addr vec%0d", i), d, TABLE[i].exp_addr);
            bus_write(6'h08, 32'h0);
        end

        // R3 combinational fast path, mid-cycle
        @(negedge clk); irq = 32'h4; #1;
        check("R3 nfiq no edge low", {31'b0, nfiq}, 32'd0);
        irq = 32'h0; #1;
        check("R3 nfiq no edge high", {31'b0, nfiq}, 32'd1);

        // R6 R7 nesting slots 3, 1, 0
        irq = 32'h0000_2000; tick();
        bus_read(6'h08, d); check("R6 take slot3", d, 32'h1030);
        check("R6 slot3 masks itself", {31'b0, nirq}, 32'd1);
        irq |= 32'h0000_0800; #1;
        check("R6 slot1 preempts", {31'b0, nirq}, 32'd0);
        bus_read(6'h08, d); check("R6 take slot1", d, 32'h1010);
        irq |= 32'h0000_0400; #1;
        bus_read(6'h08, d); check("R6 take slot0", d, 32'h1000);
        irq |= 32'h0010_0000; #1;
        check("R6 lower masked", {31'b0, nirq}, 32'd1);
        irq &= ~32'h0000_0400; bus_write(6'h08, 32'h0);
        check("R7 end slot0 still masked", {31'b0, nirq}, 32'd1);
        irq &= ~32'h0000_0800; bus_write(6'h08, 32'h0);
        check("R7 end slot1 still masked", {31'b0, nirq}, 32'd1);
        irq &= ~32'h0000_2000; bus_write(6'h08, 32'h0);
        check("R7 end slot3 releases", {31'b0, nirq}, 32'd0);
        bus_read(6'h08, d); check("R7 lower now served", d, 32'h10F0);
        irq = 32'h0; bus_write(6'h08, 32'h0);

        // R8 transient request
        irq = 32'h0000_2000; tick();
        irq = 32'h0; #1;
        bus_read(6'h08, d); check("R8 latched address", d, 32'h1030);
        irq = 32'h0010_0000; #1;
        check("R8 no level set", {31'b0, nirq}, 32'd0);
        bus_read(6'h08, d); check("R8 lower served", d, 32'h10F0);
        irq = 32'h0; bus_write(6'h08, 32'h0);

        // R2 enable clear / set
        bus_write(6'h04, 32'h0000_2000);
        irq = 32'h0000_2000; tick();
        check("R2 disabled nirq", {31'b0, nirq}, 32'd1);
        bus_read(6'h02, d); check("R2 gen status", d, 32'h0);
        bus_write(6'h03, 32'h0000_2000);
        check("R2 reenabled nirq", {31'b0, nirq}, 32'd0);
        bus_read(6'h02, d); check("R2 gen status set", d, 32'h0000_2000);
        irq = 32'h0;

        // R1 soft request
        bus_write(6'h06, 32'h0000_0800);
        bus_read(6'h06, d); check("R1 soft readback", d, 32'h0000_0800);
        irq = 32'h0000_0001; #1;
        bus_read(6'h00, d); check("R1 raw status", d, 32'h0000_0801);
        irq = 32'h0;
        check("R1 soft nirq", {31'b0, nirq}, 32'd0);
        bus_read(6'h08, d); check("R1 soft vector", d, 32'h1010);
        bus_write(6'h06, 32'h0);
        bus_write(6'h08, 32'h0);
        check("R1 cleared nirq", {31'b0, nirq}, 32'd1);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule